// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block sets the bit and frame timing of a multi-slot PCM/TDM audio link. It keeps a bit position counter that runs from zero up to a programmable divider value, so every frame is divider+1 bit periods long. From that position it derives a frame sync pulse, the index of the current slot and the index of the current bit inside the slot. The serializers next to it use these indices to shift data in and out.

As timing master, the block moves forward one bit each time a bit tick arrives from a divider on the system clock. It drives the frame sync in one of two shapes. The short shape lasts one bit and can be placed late, in the first bit of the frame, or early, in the last bit of the previous frame. The long shape covers the whole first slot. As timing slave, the block passes the external bit clock and frame sync through synchronizers. It counts bits on the rising edges of the external bit clock and realigns its position wherever the sampled external sync rises.

A global enable gates all activity. A legality checker compares the frame length against the slot geometry. If the frame is illegal, it raises an error flag and holds the counter at frame start.

Top module: `tdm_frame_timer`

## Requirements
- R1: After reset, fsync_out, bclk_en, cfg_err, slot_idx and bit_idx are all 0.
- R2: In master mode, while active (glb_en=1 and cfg_err=0), the position advances by one on each bit_tick and wraps from frame_div back to 0. A frame therefore lasts frame_div+1 bits, and slot_idx and bit_idx are 0 again after the wrap.
- R3: With sync_long=0 and sync_early=0 (late short sync), fsync_out is high in master mode only while the position is 0.
- R4: With sync_long=0 and sync_early=1 (early short sync), fsync_out is high in master mode only while the position equals frame_div, which is the last bit of the frame.
- R5: With sync_long=1, fsync_out is high in master mode while the position is below the slot length, and sync_early has no effect.
- R6: The slot length code on slot_len selects the slot size: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits. bit_idx equals the position modulo the slot length, and slot_idx equals the position divided by the slot length.
- R7: cfg_err is 1 one clock after any of these configurations is applied: slot_len=3, slot_cnt above MAX_SLOTS (default 8), or frame_div+1 below slot length times slot_cnt. While cfg_err is 1, fsync_out and bclk_en stay 0 and both indices stay 0. A frame exactly equal to slot length times slot_cnt is legal.
- R8: With sync_long=1 and slot_cnt at most 1, cfg_err is 1 when frame_div+1 is not larger than the slot length.
- R9: While glb_en=0, bclk_en and fsync_out are 0 and both indices are 0.
- R10: In master mode, bclk_en equals bit_tick while the block is active. In slave mode, bit_tick is ignored and bclk_en pulses only on a synchronized rising edge of ext_bclk.
- R11: In slave mode, fsync_out stays 0. The bit sampled on a rising ext_bclk edge, when ext_fsync has risen, becomes position 0 for late short sync and for long sync, and becomes position frame_div for early short sync. After the first sync, the indices follow the frame the external master drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable for all timing activity |
| role_slave | input | 1 | 0 = timing master, 1 = timing slave |
| sync_long | input | 1 | 0 = short sync, 1 = long sync |
| sync_early | input | 1 | Short sync placement: 0 = late, 1 = early |
| slot_len | input | 2 | Slot length code: 0 = 8, 1 = 16, 2 = 32 bits, 3 = illegal |
| slot_cnt | input | CNT_W | Number of active slots |
| frame_div | input | DIV_W | Bits per frame minus one |
| bit_tick | input | 1 | Master-mode bit advance strobe |
| ext_bclk | input | 1 | External bit clock (slave mode, asynchronous) |
| ext_fsync | input | 1 | External frame sync (slave mode, asynchronous) |
| bclk_en | output | 1 | One-cycle strobe for each bit period |
| fsync_out | output | 1 | Frame sync driven in master mode |
| slot_idx | output | DIV_W-3 | Current slot index within the frame |
| bit_idx | output | 5 | Current bit index within the slot |
| cfg_err | output | 1 | Registered frame legality error flag |

## Verification
In master mode the bench runs three kinds of frame: directed late short, early short and long frames, then random legal geometries with random gaps between bit ticks. The directed frames separate the three sync placements, including long sync with the early bit set. The random geometries catch wrap and index errors that only appear at particular slot sizes and counts. Illegal configurations sit just below the limits of both legality rules, next to a frame exactly at the limit, so that an off-by-one in either comparison shows up. Slave runs drive the external clock and sync while bit_tick is held high, which shows both whether the realignment is right for each sync shape and whether the master tick leaks into slave timing.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;

   typedef enum logic [1:0] {
      SLOT_8   = 2'd0,
      SLOT_16  = 2'd1,
      SLOT_32  = 2'd2,
      SLOT_BAD = 2'd3
   } slot_len_e;

   localparam int BIT_W = 5;

   function automatic logic [5:0] slot_bits(input logic [1:0] code);
      case (slot_len_e'(code))
         SLOT_8:  slot_bits = 6'd8;
         SLOT_16: slot_bits = 6'd16;
         SLOT_32: slot_bits = 6'd32;
         default: slot_bits = 6'd8;
      endcase
   endfunction

   function automatic logic [2:0] slot_shift(input logic [1:0] code);
      case (slot_len_e'(code))
         SLOT_8:  slot_shift = 3'd3;
         SLOT_16: slot_shift = 3'd4;
         SLOT_32: slot_shift = 3'd5;
         default: slot_shift = 3'd3;
      endcase
   endfunction

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check
   import tdm_frame_pkg::*;
#(
   parameter int DIV_W     = 10,
   parameter int CNT_W     = 4,
   parameter int MAX_SLOTS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] frame_div,
   input  logic [1:0]       slot_len,
   input  logic [CNT_W-1:0] slot_cnt,
   input  logic             sync_long,
   output logic             cfg_err
);
   localparam int LEN_W  = DIV_W + 1;
   localparam int NEED_W = CNT_W + 6;
   localparam int CMP_W  = (LEN_W > NEED_W) ? LEN_W : NEED_W;

   logic [CMP_W-1:0] frame_len;
   logic [CMP_W-1:0] need_len;
   logic [CMP_W-1:0] one_slot;
   logic             bad_code;
   logic             too_many;
   logic             too_short;
   logic             long_tight;
   logic             err_d;

   always_comb begin
      frame_len  = CMP_W'(frame_div) + CMP_W'(1);
      one_slot   = CMP_W'(slot_bits(slot_len));
      need_len   = one_slot * CMP_W'(slot_cnt);
      bad_code   = (slot_len == SLOT_BAD);
      too_many   = (slot_cnt > CNT_W'(MAX_SLOTS));
      too_short  = (frame_len < need_len);
      long_tight = sync_long && (slot_cnt <= CNT_W'(1)) && (frame_len <= one_slot);
      err_d      = bad_code | too_many | too_short | long_tight;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= err_d;
   end
endmodule

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter #(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             step,
   input  logic             resync,
   input  logic [DIV_W-1:0] resync_val,
   input  logic [DIV_W-1:0] frame_div,
   output logic [DIV_W-1:0] pos
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (!active) begin
         pos <= '0;
      end else if (step) begin
         if (resync)                 pos <= resync_val;
         else if (pos >= frame_div)  pos <= '0;
         else                        pos <= pos + DIV_W'(1);
      end
   end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
   import tdm_frame_pkg::*;
#(
   parameter int DIV_W       = 10,
   parameter int CNT_W       = 4,
   parameter int MAX_SLOTS   = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SLAVE_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glb_en,
   input  logic             role_slave,
   input  logic             sync_long,
   input  logic             sync_early,
   input  logic [1:0]       slot_len,
   input  logic [CNT_W-1:0] slot_cnt,
   input  logic [DIV_W-1:0] frame_div,
   input  logic             bit_tick,
   input  logic             ext_bclk,
   input  logic             ext_fsync,
   output logic             bclk_en,
   output logic             fsync_out,
   output logic [DIV_W-4:0] slot_idx,
   output logic [4:0]       bit_idx,
   output logic             cfg_err
);
   localparam int SLOT_W = DIV_W - 3;

   if (DIV_W < 6) begin : g_bad_div
      $error("DIV_W must hold at least one 32-bit slot");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MAX_SLOTS < 1 || MAX_SLOTS >= (1 << CNT_W)) begin : g_bad_slots
      $error("MAX_SLOTS must fit in CNT_W bits");
   end

   logic             active;
   logic             step;
   logic             resync;
   logic [DIV_W-1:0] resync_val;
   logic [DIV_W-1:0] pos;
   logic             slv_tick;
   logic             slv_sync_rise;
   logic [5:0]       cur_bits;
   logic [2:0]       cur_shift;
   logic             fs_raw;

   tdm_cfg_check #(
      .DIV_W     (DIV_W),
      .CNT_W     (CNT_W),
      .MAX_SLOTS (MAX_SLOTS)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_div (frame_div),
      .slot_len  (slot_len),
      .slot_cnt  (slot_cnt),
      .sync_long (sync_long),
      .cfg_err   (cfg_err)
   );

   assign active = glb_en & ~cfg_err;

   if (SLAVE_EN) begin : g_slave
      logic bclk_lvl;
      logic bclk_rise;
      logic fs_lvl;
      logic fs_rise_unused;
      logic fs_last_bit;

      tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (ext_bclk),
         .level    (bclk_lvl),
         .rise     (bclk_rise)
      );

      tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (ext_fsync),
         .level    (fs_lvl),
         .rise     (fs_rise_unused)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  fs_last_bit <= 1'b0;
         else if (!active)            fs_last_bit <= 1'b0;
         else if (bclk_rise)          fs_last_bit <= fs_lvl;
      end

      assign slv_tick      = bclk_rise;
      assign slv_sync_rise = fs_lvl & ~fs_last_bit;
   end else begin : g_no_slave
      assign slv_tick      = 1'b0;
      assign slv_sync_rise = 1'b0;
   end

   always_comb begin
      if (role_slave) begin
         step   = slv_tick;
         resync = slv_sync_rise;
      end else begin
         step   = bit_tick;
         resync = 1'b0;
      end
      resync_val = (!sync_long && sync_early) ? frame_div : '0;
   end

   tdm_pos_counter #(.DIV_W(DIV_W)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .step       (step),
      .resync     (resync),
      .resync_val (resync_val),
      .frame_div  (frame_div),
      .pos        (pos)
   );

   always_comb begin
      cur_bits  = slot_bits(slot_len);
      cur_shift = slot_shift(slot_len);
      if (sync_long)       fs_raw = (pos < DIV_W'(cur_bits));
      else if (sync_early) fs_raw = (pos == frame_div);
      else                 fs_raw = (pos == '0);
   end

   assign bclk_en   = active & step;
   assign fsync_out = active & ~role_slave & fs_raw;
   assign bit_idx   = BIT_W'(pos) & BIT_W'(cur_bits - 6'd1);
   assign slot_idx  = SLOT_W'(pos >> cur_shift);
endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
   parameter int DIV_W = 10,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glb_en,
   input logic             role_slave,
   input logic             sync_long,
   input logic             sync_early,
   input logic [1:0]       slot_len,
   input logic [CNT_W-1:0] slot_cnt,
   input logic [DIV_W-1:0] frame_div,
   input logic             bit_tick,
   input logic             bclk_en,
   input logic             fsync_out,
   input logic [DIV_W-4:0] slot_idx,
   input logic [4:0]       bit_idx,
   input logic             cfg_err
);
   a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!role_slave && glb_en && !cfg_err && !bit_tick)
      |=> (!$stable(slot_len) || ($stable(bit_idx) && $stable(slot_idx))));

   a_r3_late_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!role_slave && !sync_long && !sync_early && fsync_out)
      |-> (bit_idx == 5'd0 && slot_idx == '0));

   a_r5_long_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_long && fsync_out) |-> (slot_idx == '0));

   a_r7_err_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!fsync_out && !bclk_en));

   a_r7_err_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> (bit_idx == 5'd0 && slot_idx == '0));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> (!fsync_out && !bclk_en));

   a_r9_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> (bit_idx == 5'd0 && slot_idx == '0));

   a_r10_master_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!role_slave && bclk_en) |-> bit_tick);

   a_r11_slave_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      role_slave |-> !fsync_out);
endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(
   .DIV_W (DIV_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .glb_en     (glb_en),
   .role_slave (role_slave),
   .sync_long  (sync_long),
   .sync_early (sync_early),
   .slot_len   (slot_len),
   .slot_cnt   (slot_cnt),
   .frame_div  (frame_div),
   .bit_tick   (bit_tick),
   .bclk_en    (bclk_en),
   .fsync_out  (fsync_out),
   .slot_idx   (slot_idx),
   .bit_idx    (bit_idx),
   .cfg_err    (cfg_err)
);

// File: tb/tdm_frame_timer_tb.sv
`timescale 1ns/1ps
module tdm_frame_timer_tb;
   localparam int DIV_W = 10;
   localparam int CNT_W = 4;
   localparam int HALF  = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             glb_en = 1'b0;
   logic             role_slave = 1'b0;
   logic             sync_long = 1'b0;
   logic             sync_early = 1'b0;
   logic [1:0]       slot_len = 2'd0;
   logic [CNT_W-1:0] slot_cnt = 4'd2;
   logic [DIV_W-1:0] frame_div = 10'd15;
   logic             bit_tick = 1'b0;
   logic             ext_bclk = 1'b0;
   logic             ext_fsync = 1'b0;
   logic             bclk_en;
   logic             fsync_out;
   logic [DIV_W-4:0] slot_idx;
   logic [4:0]       bit_idx;
   logic             cfg_err;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   tdm_frame_timer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .glb_en     (glb_en),
      .role_slave (role_slave),
      .sync_long  (sync_long),
      .sync_early (sync_early),
      .slot_len   (slot_len),
      .slot_cnt   (slot_cnt),
      .frame_div  (frame_div),
      .bit_tick   (bit_tick),
      .ext_bclk   (ext_bclk),
      .ext_fsync  (ext_fsync),
      .bclk_en    (bclk_en),
      .fsync_out  (fsync_out),
      .slot_idx   (slot_idx),
      .bit_idx    (bit_idx),
      .cfg_err    (cfg_err)
   );

   function automatic int bits_of(input int code);
      return 8 << code;
   endfunction

   function automatic bit exp_fs(input int p, input int div, input int code,
                                 input bit lng, input bit early);
      if (lng)   return p < bits_of(code);
      if (early) return p == div;
      return p == 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   task automatic setup(input int code, input int cnt, input int div,
                        input bit lng, input bit early, input bit slave);
      @(negedge clk);
      glb_en     = 1'b0;
      bit_tick   = 1'b0;
      slot_len   = 2'(code);
      slot_cnt   = 4'(cnt);
      frame_div  = 10'(div);
      sync_long  = lng;
      sync_early = early;
      role_slave = slave;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_pos(input int p, input int div, input int code,
                            input bit lng, input bit early);
      string fs_req;
      fs_req = lng ? "R5" : (early ? "R4" : "R3");
      chk(fs_req, int'(fsync_out), int'(exp_fs(p, div, code, lng, early)));
      chk((p == 0) ? "R2" : "R6", int'(bit_idx), p % bits_of(code));
      chk((p == 0) ? "R2" : "R6", int'(slot_idx), p / bits_of(code));
   endtask

   task automatic run_master(input int code, input int cnt, input int div,
                             input bit lng, input bit early, input int nbits);
      int p;
      setup(code, cnt, div, lng, early, 1'b0);
      chk("R7", int'(cfg_err), 0);
      glb_en = 1'b1;
      p = 0;
      #1 check_pos(p, div, code, lng, early);
      for (int b = 0; b < nbits; b++) begin
         int gap;
         gap = int'($urandom % 3);
         repeat (gap) @(negedge clk);
         @(negedge clk);
         bit_tick = 1'b1;
         #1 chk("R10", int'(bclk_en), 1);
         @(negedge clk);
         bit_tick = 1'b0;
         p = (p >= div) ? 0 : p + 1;
         #1 check_pos(p, div, code, lng, early);
      end
      @(negedge clk);
      glb_en = 1'b0;
   endtask

   task automatic run_illegal(input int code, input int cnt, input int div,
                              input bit lng, input string req);
      setup(code, cnt, div, lng, 1'b0, 1'b0);
      chk(req, int'(cfg_err), 1);
      glb_en = 1'b1;
      for (int b = 0; b < 12; b++) begin
         @(negedge clk);
         bit_tick = 1'b1;
         #1 chk(req, int'(bclk_en), 0);
         chk(req, int'(fsync_out), 0);
         @(negedge clk);
         bit_tick = 1'b0;
         #1 chk(req, int'(bit_idx) + int'(slot_idx), 0);
      end
      @(negedge clk);
      glb_en = 1'b0;
   endtask

   task automatic run_slave(input int code, input int cnt, input int div,
                            input bit lng, input bit early);
      int flen;
      setup(code, cnt, div, lng, early, 1'b1);
      glb_en   = 1'b1;
      bit_tick = 1'b1;
      flen = div + 1;
      for (int f = 0; f < 3; f++) begin
         for (int q = 0; q < flen; q++) begin
            ext_fsync = exp_fs(q, div, code, lng, early);
            repeat (HALF) @(negedge clk);
            ext_bclk = 1'b1;
            repeat (HALF) @(negedge clk);
            #1;
            if (f > 0) begin
               chk("R11", int'(bit_idx), q % bits_of(code));
               chk("R11", int'(slot_idx), q / bits_of(code));
               chk("R11", int'(fsync_out), 0);
               chk("R10", int'(bclk_en), 0);
            end
            ext_bclk = 1'b0;
         end
      end
      @(negedge clk);
      bit_tick  = 1'b0;
      ext_fsync = 1'b0;
      glb_en    = 1'b0;
      role_slave = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      #1;
      chk("R1", int'(fsync_out), 0);
      chk("R1", int'(bclk_en), 0);
      chk("R1", int'(slot_idx) + int'(bit_idx), 0);
      chk("R1", int'(cfg_err), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: disabled block ignores ticks
      repeat (2) @(negedge clk);
      for (int b = 0; b < 6; b++) begin
         bit_tick = 1'b1;
         #1 chk("R9", int'(bclk_en), 0);
         chk("R9", int'(fsync_out), 0);
         @(negedge clk);
         bit_tick = 1'b0;
         #1 chk("R9", int'(bit_idx) + int'(slot_idx), 0);
         @(negedge clk);
      end

      // directed sync placements
      run_master(0, 2, 15, 1'b0, 1'b0, 40);
      run_master(0, 2, 15, 1'b0, 1'b1, 40);
      run_master(1, 2, 31, 1'b1, 1'b1, 70);
      run_master(2, 1, 32, 1'b1, 1'b0, 70);
      // R7 boundary: frame exactly slots times slot length
      run_master(1, 3, 47, 1'b0, 1'b0, 50);

      // illegal geometries
      run_illegal(0, 2, 14, 1'b0, "R7");
      run_illegal(3, 1, 63, 1'b0, "R7");
      run_illegal(0, 9, 127, 1'b0, "R7");
      run_illegal(0, 1, 7, 1'b1, "R8");
      run_illegal(1, 0, 15, 1'b1, "R8");
      // R8 boundary: one bit longer than the slot is legal
      run_master(0, 1, 8, 1'b1, 1'b0, 20);

      // random legal geometries
      for (int r = 0; r < 8; r++) begin
         int code, cnt, div, minlen;
         bit lng, early;
         code  = int'($urandom % 3);
         cnt   = 1 + int'($urandom % 8);
         lng   = 1'($urandom % 2);
         early = 1'($urandom % 2);
         minlen = bits_of(code) * cnt;
         if (lng && cnt <= 1) minlen = bits_of(code) + 1;
         div = minlen - 1 + int'($urandom % 8);
         run_master(code, cnt, div, lng, early, 2 * (div + 1) + 3);
      end

      // slave tracking
      run_slave(0, 2, 15, 1'b0, 1'b0);
      run_slave(0, 2, 15, 1'b0, 1'b1);
      run_slave(0, 2, 15, 1'b1, 1'b0);

      report();
   end
endmodule